// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Transfer Engine

This engine moves data out of a firmware configuration item store into system memory without the host reading it byte by byte. Software places a 16-byte descriptor in RAM and writes the descriptor's 64-bit address into a two-half address register. A write to the lower half launches the operation. The engine reads the descriptor through a byte-wide memory master port. It can change which item is selected. It then either copies a number of bytes from the current item position into RAM or only moves the item position forward. At the end it stores a status word over the descriptor's first four bytes.

The item store is outside the block. The engine presents a key and a byte offset to it and receives the item's size and the byte at that offset, both combinationally. The engine keeps the selected key and the running offset between operations. A later descriptor without a selection therefore continues where the last one stopped. Status in the descriptor's first word is zero on success and 0x00000001 on failure.

Top module: `cfgdma_engine`

## Requirements
- R1: The address register's most significant half is at byte offset 0x10 and its least significant half is at 0x14. Writing 0x14 while idle starts an operation whose descriptor address is {upper half, written value}. Writing 0x10 alone starts nothing.
- R2: Both halves reset to zero and return to zero when an operation ends. While idle, reading 0x10 returns 0x51454D55 and reading 0x14 returns 0x20434647. While busy, each offset returns the held half of the descriptor address.
- R3: The descriptor is fetched as 16 single-byte reads at ascending addresses from its base. Bytes 0 to 3 hold the control word, bytes 4 to 7 the length and bytes 8 to 15 the target address. Each field has its most significant byte first.
- R4: When control bit 3 is set, the item key becomes control bits 31:16 and the item offset becomes 0. Both take effect before any transfer.
- R5: When control bit 1 is set, length bytes of the item, starting at the current offset, are written to ascending target addresses. The offset advances by one for each byte written.
- R6: When control bit 2 is set and bit 1 is clear, the offset advances by length and no data is written. When both bits are set, the operation is a read.
- R7: Every operation ends with four byte writes to the descriptor base, most significant byte first. The status word is 0x00000000 on success and 0x00000001 on error.
- R8: If offset plus length exceeds the item size, a read or skip writes no data, leaves the offset unchanged and reports an error. An exact fit is accepted.
- R9: A memory fault reported on a descriptor read or a data write stops the operation and reports an error. Bytes already transferred keep their offset advance.
- R10: The busy output goes high in the cycle after the starting write and stays high until the last status byte is accepted. Register writes made while busy have no effect.
- R11: A memory request holds its address, direction and write data unchanged until the responder accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write value (numeric value of the half) |
| reg_rdata | output | 32 | Register read value for reg_addr |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Responder accepts the request this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_err | input | 1 | Fault on the accepted access, valid with mem_ready |
| item_sel | output | 1 | One-cycle pulse when a new key is applied |
| item_key | output | 16 | Selected item key |
| item_offset | output | 32 | Current byte offset in the item |
| item_size | input | 32 | Size in bytes of the selected item |
| item_data | input | 8 | Item byte at item_key / item_offset |

## Verification
The checker follows several rules in every cycle. A stalled memory request must hold steady. No memory traffic may occur while idle. Busy may only rise after a write to the lower half. A selection must reset the offset. The offset must never move while the engine is idle. The idle signature readback is also checked every cycle. Descriptor field order, the decisions for read, skip, overrun and fault, the continuation of the offset across operations, and the clearing of the upper half appear only in the bench's operation sequences. There, a scoreboard compares every memory access against a model of the item store.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_CHECK,
      ST_XFER,
      ST_WBACK
   } seq_state_t;

   // control word bit positions (decoded by software, fixed)
   localparam int CTL_ERR  = 0;
   localparam int CTL_READ = 1;
   localparam int CTL_SKIP = 2;
   localparam int CTL_SEL  = 3;

   localparam int DESC_BYTES = 16;
   localparam int STAT_BYTES = 4;

endpackage

// File: rtl/cfgdma_addr_reg.sv
module cfgdma_addr_reg #(
   parameter int              ADDR_W = 64,
   parameter int              REG_AW = 5,
   parameter logic [REG_AW-1:0] HI_OFF = 5'h10,
   parameter logic [REG_AW-1:0] LO_OFF = 5'h14,
   parameter logic [63:0]     SIG    = 64'h51454D5520434647
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              op_done,
   output logic              start,
   output logic [ADDR_W-1:0] start_addr
);

   localparam int HALF_W = ADDR_W / 2;

   if (ADDR_W != 64) begin : g_bad_width
      $error("cfgdma_addr_reg: ADDR_W must be 64");
   end

   logic [HALF_W-1:0] hi_q, lo_q;
   logic              wr_hi, wr_lo;

   assign wr_hi = reg_wr && (reg_addr == HI_OFF) && !busy;
   assign wr_lo = reg_wr && (reg_addr == LO_OFF) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (op_done) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (wr_hi) hi_q <= reg_wdata;
         if (wr_lo) lo_q <= reg_wdata;
      end
   end

   assign start      = wr_lo;
   assign start_addr = {hi_q, reg_wdata};

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == HI_OFF)
         reg_rdata = busy ? hi_q : SIG[63:32];
      else if (reg_addr == LO_OFF)
         reg_rdata = busy ? lo_q : SIG[31:0];
   end

endmodule

// File: rtl/cfgdma_desc_buf.sv
module cfgdma_desc_buf
   import cfgdma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic [$clog2(DESC_BYTES)-1:0] cap_idx,
   input  logic [7:0]                    cap_byte,
   output logic [31:0]                   ctl,
   output logic [LEN_W-1:0]              len,
   output logic [ADDR_W-1:0]             dst
);

   localparam int IDX_W  = $clog2(DESC_BYTES);
   localparam int FLAT_W = DESC_BYTES * 8;

   if (FLAT_W != 32 + LEN_W + ADDR_W) begin : g_bad_layout
      $error("cfgdma_desc_buf: field widths do not fill the descriptor");
   end

   logic [FLAT_W-1:0] flat;

   // byte 0 lands in the most significant position: big-endian fields
   for (genvar i = 0; i < DESC_BYTES; i++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (cap_en && cap_idx == IDX_W'(i))
            q <= cap_byte;
      end
      assign flat[(DESC_BYTES-1-i)*8 +: 8] = q;
   end

   assign ctl = flat[FLAT_W-1 -: 32];
   assign len = flat[FLAT_W-33 -: LEN_W];
   assign dst = flat[ADDR_W-1:0];

endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
   import cfgdma_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int LEN_W       = 32,
   parameter int KEY_W       = 16,
   parameter bit BOUND_CHECK = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [ADDR_W-1:0]             start_addr,
   output logic                          busy,
   output logic                          op_done,
   output logic                          cap_en,
   output logic [$clog2(DESC_BYTES)-1:0] cap_idx,
   input  logic [31:0]                   ctl,
   input  logic [LEN_W-1:0]              len,
   input  logic [ADDR_W-1:0]             dst,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [7:0]                    mem_wdata,
   input  logic                          mem_ready,
   input  logic                          mem_err,
   output logic                          item_sel,
   output logic [KEY_W-1:0]              item_key,
   output logic [LEN_W-1:0]              item_offset,
   input  logic [LEN_W-1:0]              item_size,
   input  logic [7:0]                    item_data
);

   localparam int IDX_W = $clog2(DESC_BYTES);
   localparam logic [LEN_W-1:0] LAST_DESC = LEN_W'(DESC_BYTES - 1);
   localparam logic [LEN_W-1:0] LAST_STAT = LEN_W'(STAT_BYTES - 1);

   if (KEY_W != 16) begin : g_bad_key
      $error("cfgdma_seq: KEY_W must be 16 (control bits 31:16)");
   end
   if (ADDR_W < LEN_W) begin : g_bad_addr
      $error("cfgdma_seq: ADDR_W must be at least LEN_W");
   end

   seq_state_t        st_q;
   logic [LEN_W-1:0]  cnt_q, off_q;
   logic [ADDR_W-1:0] base_q;
   logic [KEY_W-1:0]  key_q;
   logic              err_q, sel_q;
   logic              hs, overrun, want_read, want_move;
   logic              unused_ctl;

   assign hs        = mem_req && mem_ready;
   assign want_read = ctl[CTL_READ];
   assign want_move = ctl[CTL_READ] || ctl[CTL_SKIP];
   assign unused_ctl = ^{ctl[15:4], ctl[CTL_ERR]};

   if (BOUND_CHECK) begin : g_bound
      logic [LEN_W:0] end_pos;
      assign end_pos = {1'b0, off_q} + {1'b0, len};
      assign overrun = end_pos > {1'b0, item_size};
   end else begin : g_nobound
      logic unused_size;
      assign unused_size = ^item_size;
      assign overrun = 1'b0;
   end

   // memory master outputs are decoded from held state: stable under stall
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = 8'h00;
      unique case (st_q)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = base_q + ADDR_W'(cnt_q);
         end
         ST_XFER: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst + ADDR_W'(cnt_q);
            mem_wdata = item_data;
         end
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base_q + ADDR_W'(cnt_q);
            mem_wdata = (cnt_q == LAST_STAT) ? {7'b0, err_q} : 8'h00;
         end
         default: ;
      endcase
   end

   assign cap_en  = (st_q == ST_FETCH) && hs && !mem_err;
   assign cap_idx = cnt_q[IDX_W-1:0];
   assign busy    = (st_q != ST_IDLE);
   assign op_done = (st_q == ST_WBACK) && hs && (cnt_q == LAST_STAT);

   assign item_sel    = sel_q;
   assign item_key    = key_q;
   assign item_offset = off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         off_q  <= '0;
         base_q <= '0;
         key_q  <= '0;
         err_q  <= 1'b0;
         sel_q  <= 1'b0;
      end else begin
         sel_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  base_q <= start_addr;
                  cnt_q  <= '0;
                  err_q  <= 1'b0;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (hs) begin
                  if (mem_err) begin
                     err_q <= 1'b1;
                     cnt_q <= '0;
                     st_q  <= ST_WBACK;
                  end else if (cnt_q == LAST_DESC) begin
                     cnt_q <= '0;
                     st_q  <= ST_DECODE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_DECODE: begin
               if (ctl[CTL_SEL]) begin
                  key_q <= ctl[31 -: KEY_W];
                  off_q <= '0;
                  sel_q <= 1'b1;
               end
               st_q <= ST_CHECK;
            end
            ST_CHECK: begin
               cnt_q <= '0;
               if (!want_move) begin
                  st_q <= ST_WBACK;
               end else if (overrun) begin
                  err_q <= 1'b1;
                  st_q  <= ST_WBACK;
               end else if (want_read) begin
                  st_q <= (len == '0) ? ST_WBACK : ST_XFER;
               end else begin
                  off_q <= off_q + len;
                  st_q  <= ST_WBACK;
               end
            end
            ST_XFER: begin
               if (hs) begin
                  if (mem_err) begin
                     err_q <= 1'b1;
                     cnt_q <= '0;
                     st_q  <= ST_WBACK;
                  end else begin
                     off_q <= off_q + 1'b1;
                     if (cnt_q == len - 1'b1) begin
                        cnt_q <= '0;
                        st_q  <= ST_WBACK;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            end
            ST_WBACK: begin
               if (hs) begin
                  if (cnt_q == LAST_STAT) begin
                     cnt_q <= '0;
                     st_q  <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
   import cfgdma_pkg::*;
#(
   parameter int                ADDR_W      = 64,
   parameter int                LEN_W       = 32,
   parameter int                KEY_W       = 16,
   parameter int                REG_AW      = 5,
   parameter logic [REG_AW-1:0] HI_OFF      = 5'h10,
   parameter logic [REG_AW-1:0] LO_OFF      = 5'h14,
   parameter logic [63:0]       SIG         = 64'h51454D5520434647,
   parameter bit                BOUND_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ready,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_err,
   output logic              item_sel,
   output logic [KEY_W-1:0]  item_key,
   output logic [LEN_W-1:0]  item_offset,
   input  logic [LEN_W-1:0]  item_size,
   input  logic [7:0]        item_data
);

   localparam int IDX_W = $clog2(DESC_BYTES);

   if (LEN_W != 32) begin : g_bad_len
      $error("cfgdma_engine: LEN_W must be 32");
   end
   if (HI_OFF == LO_OFF) begin : g_bad_off
      $error("cfgdma_engine: register halves need distinct offsets");
   end

   logic              start, op_done;
   logic [ADDR_W-1:0] start_addr;
   logic              cap_en;
   logic [IDX_W-1:0]  cap_idx;
   logic [31:0]       d_ctl;
   logic [LEN_W-1:0]  d_len;
   logic [ADDR_W-1:0] d_dst;

   cfgdma_addr_reg #(
      .ADDR_W (ADDR_W),
      .REG_AW (REG_AW),
      .HI_OFF (HI_OFF),
      .LO_OFF (LO_OFF),
      .SIG    (SIG)
   ) u_areg (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .busy       (busy),
      .op_done    (op_done),
      .start      (start),
      .start_addr (start_addr)
   );

   cfgdma_desc_buf #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_byte (mem_rdata),
      .ctl      (d_ctl),
      .len      (d_len),
      .dst      (d_dst)
   );

   cfgdma_seq #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .KEY_W       (KEY_W),
      .BOUND_CHECK (BOUND_CHECK)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_addr  (start_addr),
      .busy        (busy),
      .op_done     (op_done),
      .cap_en      (cap_en),
      .cap_idx     (cap_idx),
      .ctl         (d_ctl),
      .len         (d_len),
      .dst         (d_dst),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ready   (mem_ready),
      .mem_err     (mem_err),
      .item_sel    (item_sel),
      .item_key    (item_key),
      .item_offset (item_offset),
      .item_size   (item_size),
      .item_data   (item_data)
   );

endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk #(
   parameter int                ADDR_W = 64,
   parameter int                LEN_W  = 32,
   parameter int                REG_AW = 5,
   parameter logic [REG_AW-1:0] HI_OFF = 5'h10,
   parameter logic [REG_AW-1:0] LO_OFF = 5'h14,
   parameter logic [63:0]       SIG    = 64'h51454D5520434647
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_ready,
   input logic              item_sel,
   input logic [LEN_W-1:0]  item_offset
);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == LO_OFF));

   // R4
   sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      item_sel |-> item_offset == '0);

   // R2
   sig_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && reg_addr == HI_OFF |-> reg_rdata == SIG[63:32]);

   // R5
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(item_offset));

endmodule

bind cfgdma_engine cfgdma_engine_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .REG_AW (REG_AW),
   .HI_OFF (HI_OFF),
   .LO_OFF (LO_OFF),
   .SIG    (SIG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_rdata   (reg_rdata),
   .busy        (busy),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ready   (mem_ready),
   .item_sel    (item_sel),
   .item_offset (item_offset)
);

// File: tb/cfgdma_engine_bench.sv
module cfgdma_engine_bench;

   localparam logic [4:0] HI = 5'h10;
   localparam logic [4:0] LO = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = 5'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        busy;
   logic        mem_req, mem_we, mem_ready, mem_err;
   logic [63:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        item_sel;
   logic [15:0] item_key;
   logic [31:0] item_offset, item_size;
   logic [7:0]  item_data;

   logic [7:0]  ram [256];
   logic [72:0] exp_q [$];
   logic [72:0] mon_got, mon_exp;
   logic [7:0]  lfsr = 8'h5B;
   logic        stall_en = 1'b0;
   logic        wd_fail = 1'b0;
   int          n_chk = 0, n_fail = 0, sb_chk = 0, sb_fail = 0;
   logic [15:0] mkey = 16'h0;
   logic [31:0] moff = 32'h0;

   always #5 clk = ~clk;

   function automatic logic [31:0] isize(input logic [15:0] k);
      return {16'h0, k} * 32'd4 + 32'd8;
   endfunction

   function automatic logic [7:0] idata(input logic [15:0] k, input logic [31:0] o);
      return k[7:0] ^ o[7:0] ^ 8'hA5;
   endfunction

   assign mem_rdata = ram[mem_addr[7:0]];
   assign mem_err   = (mem_addr[63:60] == 4'hF);
   assign item_size = isize(item_key);
   assign item_data = idata(item_key, item_offset);

   cfgdma_engine u_cfgdma_engine (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .busy (busy),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata),
      .mem_err (mem_err),
      .item_sel (item_sel), .item_key (item_key), .item_offset (item_offset),
      .item_size (item_size), .item_data (item_data)
   );

   // responder: ready changes shortly after the rising edge
   always @(posedge clk) begin
      #2;
      if (stall_en) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_ready = lfsr[0];
      end else begin
         mem_ready = 1'b1;
      end
   end

   // scoreboard monitor: every accepted access, in order (R3 R5 R7 R9)
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ready) begin
         mon_got = {mem_we, mem_addr, mem_we ? mem_wdata : 8'h00};
         sb_chk++;
         if (exp_q.size() == 0) begin
            sb_fail++;
            $display("FAIL R3 R5 R7 R10 unexpected access: got %h expected none", mon_got);
         end else begin
            mon_exp = exp_q.pop_front();
            if (mon_got !== mon_exp) begin
               sb_fail++;
               $display("FAIL R3 R5 R7 R9 access order: got %h expected %h", mon_got, mon_exp);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic push(input logic we, input logic [63:0] a, input logic [7:0] d);
      exp_q.push_back({we, a, d});
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed",
               n_chk + sb_chk + 32'(wd_fail), n_fail + sb_fail + 32'(wd_fail));
   endtask

   // driver: load descriptor, predict every access, trigger, wait
   task automatic run_op(input string name, input logic [63:0] desc, input logic [31:0] ctl,
                         input logic [31:0] len, input logic [63:0] dst,
                         input bit fetch_fault, input bit poke);
      logic        errv;
      logic [63:0] a;
      logic [31:0] rd;
      errv = 1'b0;
      if (!fetch_fault) begin
         for (int i = 0; i < 4; i++) begin
            ram[desc[7:0] + 8'(i)]     = ctl[31-8*i -: 8];
            ram[desc[7:0] + 8'(4 + i)] = len[31-8*i -: 8];
         end
         for (int i = 0; i < 8; i++)
            ram[desc[7:0] + 8'(8 + i)] = dst[63-8*i -: 8];
         for (int i = 0; i < 16; i++)
            push(1'b0, desc + 64'(i), 8'h00);
         if (ctl[3]) begin
            mkey = ctl[31:16];
            moff = 32'h0;
         end
         if (ctl[1] || ctl[2]) begin
            if ({1'b0, moff} + {1'b0, len} > {1'b0, isize(mkey)}) begin
               errv = 1'b1;
            end else if (ctl[1]) begin
               for (int i = 0; i < int'(len); i++) begin
                  a = dst + 64'(i);
                  push(1'b1, a, idata(mkey, moff));
                  if (a[63:60] == 4'hF) begin
                     errv = 1'b1;
                     break;
                  end
                  moff = moff + 32'd1;
               end
            end else begin
               moff = moff + len;
            end
         end
      end else begin
         push(1'b0, desc, 8'h00);
         errv = 1'b1;
      end
      for (int i = 0; i < 4; i++)
         push(1'b1, desc + 64'(i), (i == 3) ? {7'b0, errv} : 8'h00);

      if (desc[63:32] != 32'h0) begin
         reg_write(HI, desc[63:32]);
         check({name, " R1 upper-half write alone starts nothing"}, 64'(busy), 64'd0);
      end
      reg_write(LO, desc[31:0]);
      check({name, " R10 busy after trigger"}, 64'(busy), 64'd1);
      if (poke) begin
         reg_read(HI, rd);
         check({name, " R2 held upper half while busy"}, 64'(rd), 64'(desc[63:32]));
         reg_read(LO, rd);
         check({name, " R2 held lower half while busy"}, 64'(rd), 64'(desc[31:0]));
         reg_write(LO, 32'h0000_0040);
         check({name, " R10 busy kept through ignored write"}, 64'(busy), 64'd1);
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      check({name, " R7 all predicted accesses done"}, 64'(exp_q.size()), 64'd0);
      if (poke) begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check({name, " R10 write during busy launched nothing"}, 64'(busy), 64'd0);
         end
      end
      check({name, " R4 R5 R6 key"}, 64'(item_key), 64'(mkey));
      check({name, " R5 R6 R8 R9 offset"}, 64'(item_offset), 64'(moff));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      wd_fail = 1'b1;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset R10 busy low", 64'(busy), 64'd0);
      check("reset R10 no request", 64'(mem_req), 64'd0);
      check("reset R5 offset zero", 64'(item_offset), 64'd0);
      reg_read(HI, rd);
      check("reset R2 signature upper", 64'(rd), 64'h51454D55);
      reg_read(LO, rd);
      check("reset R2 signature lower", 64'(rd), 64'h20434647);

      // select key 3 (20 bytes), read 8
      run_op("A", 64'h0, 32'h0003_000A, 32'd8, 64'h80, 1'b0, 1'b0);
      stall_en = 1'b1;
      // continue reading without select, 64-bit target
      run_op("B", 64'h20, 32'h0000_0002, 32'd4, 64'h1_0000_0090, 1'b0, 1'b0);
      // skip 4
      run_op("C", 64'h40, 32'h0000_0004, 32'd4, 64'h0, 1'b0, 1'b0);
      // two-half descriptor address, exact-fit read, busy probes
      run_op("D", 64'h2_0000_0060, 32'h0000_0002, 32'd4, 64'hA0, 1'b0, 1'b1);
      // lower-half write only: upper half must have been cleared
      run_op("E", 64'h0, 32'h0003_000A, 32'd8, 64'h80, 1'b0, 1'b0);
      // read past end of item
      run_op("F", 64'h40, 32'h0000_0002, 32'd16, 64'h80, 1'b0, 1'b0);
      // exactly to the end of item
      run_op("G", 64'h60, 32'h0000_0002, 32'd12, 64'hB0, 1'b0, 1'b0);
      // write fault on the first data byte
      run_op("H", 64'h60, 32'h0001_000A, 32'd3, 64'hF000_0000_0000_0000, 1'b0, 1'b0);
      // select only
      run_op("I", 64'h20, 32'h0005_0008, 32'd9, 64'h80, 1'b0, 1'b0);
      // fault on descriptor fetch
      run_op("J", 64'hF000_0000_0000_0000, 32'h0, 32'd0, 64'h0, 1'b1, 1'b0);
      // zero-length read
      run_op("K", 64'h40, 32'h0000_0002, 32'd0, 64'h80, 1'b0, 1'b0);
      // read and skip both set: read wins
      run_op("L", 64'h40, 32'h0000_0006, 32'd2, 64'hC0, 1'b0, 1'b0);
      // skip past end of item
      run_op("M", 64'h20, 32'h0000_0004, 32'd40, 64'h0, 1'b0, 1'b0);
      stall_en = 1'b0;
      reg_read(LO, rd);
      check("end R2 signature lower", 64'(rd), 64'h20434647);

      summary();
      $finish;
   end

endmodule